// File: doc/BRIEF.md
# Bidirectional Interrupt Line Router

This block sits inside a bus bridge. It links the seven prioritised interrupt request lines of a local backplane to the matching lines of a remote extension bus. Each request line is active-low and wired-OR, so the block only pulls a line low or lets it go. A 16-bit routing register, reached through a small read/write port, has two bits for each level. One bit enables forwarding. The other picks the way the request travels: out from the backplane to the remote bus, or in from the remote bus to the backplane.

A forwarded request passes through one register stage. The block watches the source side and drives the far side. Interrupt-acknowledge cycles go the other way. When a level's request is routed inward, the handler sits on the backplane, so an acknowledge seen on the backplane for that level is passed to the remote bus. An outward level sends remote acknowledges onto the backplane. Interrupts raised inside the bridge itself pull the backplane line directly. They reach the remote bus only through an enabled outward route.

A hard reset clears the whole routing register. A soft reset releases everything in flight but keeps the routing register as it is.

Top module: `irq_line_router`

## Requirements
- R1: Level L (1..7) uses array index L-1. Its enable bit is register bit 7+L (bits 14..8) and its direction bit is register bit L-1 (bits 6..0). Direction 1 routes backplane-to-remote and direction 0 routes remote-to-backplane. The register reads back as written.
- R2: Register bits 15 and 7 always read 0, and any value written to them is dropped.
- R3: Byte enable bit 1 writes the upper byte (enables) and byte enable bit 0 writes the lower byte (directions). Each byte can be written alone.
- R4: A hard reset (rst_n low, asynchronous) clears every enable and direction bit and releases every driven line and acknowledge output.
- R5: A soft reset (soft_rst high at a clock edge) releases all forwarded requests and acknowledge outputs from that edge on, and leaves the routing register unchanged.
- R6: For an enabled level with direction 1, an asserted backplane request drives the remote line low after the next clock edge.
- R7: For an enabled level with direction 0, an asserted remote request drives the backplane line low after the next clock edge.
- R8: A level whose enable bit is clear is forwarded in neither direction, and a request on the side opposite to the configured direction is ignored.
- R9: Apart from the bridge's own interrupt, a level is never driven on both sides at once, so a request that was forwarded is not sent back to the side it came from.
- R10: A forwarded request is released at the first clock edge after its source deasserts, and at the same edge at which its enable bit is cleared.
- R11: A local interrupt (loc_irq_n low) pulls the matching backplane line low at once, whatever the configuration. It reaches the remote line only when that level is enabled with direction 1.
- R12: An acknowledge cycle (valid with level code 1..7) is forwarded one clock later with the same level code: from the backplane to the remote bus when that level is enabled with direction 0, and from the remote bus to the backplane when it is enabled with direction 1.
- R13: An acknowledge is not forwarded when its level is disabled, when it arrives on the side opposite to its forwarding direction, or when its level code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_byte_en | input | 2 | Byte enables for the write (bit 1 upper, bit 0 lower) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| loc_irq_n | input | 7 | Bridge-internal interrupt requests, active low, index L-1 |
| bp_irq_in_n | input | 7 | Observed backplane request lines, active low |
| bp_irq_drv_n | output | 7 | Backplane pull-down controls (0 = pull low, 1 = release) |
| rm_irq_in_n | input | 7 | Observed remote request lines, active low |
| rm_irq_drv_n | output | 7 | Remote pull-down controls (0 = pull low, 1 = release) |
| bp_iack_vld | input | 1 | Acknowledge cycle present on the backplane |
| bp_iack_lvl | input | 3 | Level code of the backplane acknowledge |
| rm_iack_vld | input | 1 | Acknowledge cycle present on the remote bus |
| rm_iack_lvl | input | 3 | Level code of the remote acknowledge |
| bp_iack_fwd_vld | output | 1 | Acknowledge forwarded onto the backplane |
| bp_iack_fwd_lvl | output | 3 | Level code forwarded onto the backplane |
| rm_iack_fwd_vld | output | 1 | Acknowledge forwarded onto the remote bus |
| rm_iack_fwd_lvl | output | 3 | Level code forwarded onto the remote bus |

## Verification
The forwarding path is driven with enable and direction words that are all set, all clear, and mixed. Each word is paired with request patterns on both sides at once. These patterns separate a direction fault, which sends a level the wrong way or back to its source, from an enable fault, which leaks a disabled level, and from a bit-to-level mapping fault. Single-byte writes and all-ones writes show whether the two halves of the register and the reserved bits are decoded independently. Acknowledges are tried on both sides for outward, inward and disabled levels and for level code 0, which shows whether acknowledge steering is opposite to request routing and correctly gated. Soft and hard resets are applied with requests active. Comparing the outputs with the register readback afterwards tells the two resets apart.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
    localparam int unsigned NUM_LVL  = 7;
    localparam int unsigned LVL_W    = $clog2(NUM_LVL + 1);
    localparam int unsigned REG_W    = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NUM_BYTE = REG_W / BYTE_W;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    typedef struct packed {
        lvl_vec_t en;
        lvl_vec_t dir;
    } route_cfg_t;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
    } iack_t;
endpackage

// File: rtl/irq_cfg_reg.sv
`timescale 1ns/1ps
module irq_cfg_reg
    import irq_router_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NUM_BYTE-1:0]         byte_en,
    input  logic [REG_W-1:0]            wdata,
    output lvl_vec_t                    en,
    output lvl_vec_t                    dir,
    output logic [REG_W-1:0]            rdata
);
    localparam int unsigned EN_LSB  = BYTE_W;
    localparam int unsigned DIR_LSB = 0;

    route_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (byte_en[1]) cfg_d.en  = wdata[EN_LSB  +: NUM_LVL];
            if (byte_en[0]) cfg_d.dir = wdata[DIR_LSB +: NUM_LVL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en    = cfg_q.en;
    assign dir   = cfg_q.dir;
    // Reserved bits at the top of each byte read back as zero.
    assign rdata = {1'b0, cfg_q.en, 1'b0, cfg_q.dir};
endmodule

// File: rtl/irq_fwd_bank.sv
`timescale 1ns/1ps
module irq_fwd_bank
    import irq_router_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst,
    input  lvl_vec_t en,
    input  lvl_vec_t dir,
    input  lvl_vec_t loc_n,
    input  lvl_vec_t bp_in_n,
    input  lvl_vec_t rm_in_n,
    output lvl_vec_t bp_drv_n,
    output lvl_vec_t rm_drv_n
);
    typedef struct packed {
        lvl_vec_t to_rm;
        lvl_vec_t to_bp;
    } fwd_st_t;

    fwd_st_t st_d, st_q;

    always_comb begin
        st_d.to_rm = en &  dir & ~bp_in_n;
        st_d.to_bp = en & ~dir & ~rm_in_n;
        if (soft_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Outputs are gated by the live configuration so a disable or a
    // direction flip releases the far side on the edge that changes it.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign rm_drv_n[g] = ~(st_q.to_rm[g] & en[g] &  dir[g]);
        assign bp_drv_n[g] = ~((st_q.to_bp[g] & en[g] & ~dir[g]) | ~loc_n[g]);
    end
endmodule

// File: rtl/iack_steer.sv
`timescale 1ns/1ps
module iack_steer
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  lvl_vec_t         en,
    input  lvl_vec_t         dir,
    input  logic             bp_vld,
    input  logic [LVL_W-1:0] bp_lvl,
    input  logic             rm_vld,
    input  logic [LVL_W-1:0] rm_lvl,
    output logic             to_bp_vld,
    output logic [LVL_W-1:0] to_bp_lvl,
    output logic             to_rm_vld,
    output logic [LVL_W-1:0] to_rm_lvl
);
    typedef struct packed {
        iack_t to_bp;
        iack_t to_rm;
    } steer_st_t;

    steer_st_t st_d, st_q;

    // True when code names a level that is enabled with direction want.
    function automatic logic lvl_match(input logic [LVL_W-1:0] code,
                                       input lvl_vec_t e, input lvl_vec_t d,
                                       input logic want);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (code == LVL_W'(i + 1) && e[i] && (d[i] == want)) hit = 1'b1;
        end
        return hit;
    endfunction

    always_comb begin
        // Remote acknowledge serves an outward level; backplane one an inward level.
        st_d.to_bp.vld = rm_vld && lvl_match(rm_lvl, en, dir, 1'b1);
        st_d.to_bp.lvl = rm_lvl;
        st_d.to_rm.vld = bp_vld && lvl_match(bp_lvl, en, dir, 1'b0);
        st_d.to_rm.lvl = bp_lvl;
        if (soft_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign to_bp_vld = st_q.to_bp.vld;
    assign to_bp_lvl = st_q.to_bp.vld ? st_q.to_bp.lvl : '0;
    assign to_rm_vld = st_q.to_rm.vld;
    assign to_rm_lvl = st_q.to_rm.vld ? st_q.to_rm.lvl : '0;
endmodule

// File: rtl/irq_line_router.sv
`timescale 1ns/1ps
module irq_line_router
    import irq_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_byte_en,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [6:0]  loc_irq_n,
    input  logic [6:0]  bp_irq_in_n,
    output logic [6:0]  bp_irq_drv_n,
    input  logic [6:0]  rm_irq_in_n,
    output logic [6:0]  rm_irq_drv_n,
    input  logic        bp_iack_vld,
    input  logic [2:0]  bp_iack_lvl,
    input  logic        rm_iack_vld,
    input  logic [2:0]  rm_iack_lvl,
    output logic        bp_iack_fwd_vld,
    output logic [2:0]  bp_iack_fwd_lvl,
    output logic        rm_iack_fwd_vld,
    output logic [2:0]  rm_iack_fwd_lvl
);
    lvl_vec_t cfg_en, cfg_dir;

    irq_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .byte_en (reg_byte_en),
        .wdata   (reg_wdata),
        .en      (cfg_en),
        .dir     (cfg_dir),
        .rdata   (reg_rdata)
    );

    irq_fwd_bank u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .en       (cfg_en),
        .dir      (cfg_dir),
        .loc_n    (loc_irq_n),
        .bp_in_n  (bp_irq_in_n),
        .rm_in_n  (rm_irq_in_n),
        .bp_drv_n (bp_irq_drv_n),
        .rm_drv_n (rm_irq_drv_n)
    );

    iack_steer u_iack (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .en        (cfg_en),
        .dir       (cfg_dir),
        .bp_vld    (bp_iack_vld),
        .bp_lvl    (bp_iack_lvl),
        .rm_vld    (rm_iack_vld),
        .rm_lvl    (rm_iack_lvl),
        .to_bp_vld (bp_iack_fwd_vld),
        .to_bp_lvl (bp_iack_fwd_lvl),
        .to_rm_vld (rm_iack_fwd_vld),
        .to_rm_lvl (rm_iack_fwd_lvl)
    );
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic [15:0] reg_rdata,
    input logic [6:0]  loc_irq_n,
    input logic [6:0]  bp_irq_in_n,
    input logic [6:0]  bp_irq_drv_n,
    input logic [6:0]  rm_irq_in_n,
    input logic [6:0]  rm_irq_drv_n,
    input logic        rm_iack_vld,
    input logic [2:0]  rm_iack_lvl,
    input logic        bp_iack_vld,
    input logic [2:0]  bp_iack_lvl,
    input logic        bp_iack_fwd_vld,
    input logic [2:0]  bp_iack_fwd_lvl,
    input logic        rm_iack_fwd_vld,
    input logic [2:0]  rm_iack_fwd_lvl
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15] == 1'b0) && (reg_rdata[7] == 1'b0));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((~rm_irq_drv_n) & ~reg_rdata[14:8]) == 7'd0) &&
        (((~bp_irq_drv_n) & loc_irq_n & ~reg_rdata[14:8]) == 7'd0));

    assert_no_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((~rm_irq_drv_n) & (~bp_irq_drv_n) & loc_irq_n) == 7'd0);

    assert_rm_needs_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (((~rm_irq_drv_n) & $past(bp_irq_in_n)) == 7'd0));

    assert_bp_needs_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (((~bp_irq_drv_n) & loc_irq_n & $past(rm_irq_in_n)) == 7'd0));

    assert_soft_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> ((&rm_irq_drv_n) && !bp_iack_fwd_vld && !rm_iack_fwd_vld));

    assert_iack_to_bp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bp_iack_fwd_vld |-> ($past(rm_iack_vld) && (bp_iack_fwd_lvl == $past(rm_iack_lvl))));

    assert_iack_to_rm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rm_iack_fwd_vld |-> ($past(bp_iack_vld) && (rm_iack_fwd_lvl == $past(bp_iack_lvl))));

    assert_iack_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!bp_iack_fwd_vld || bp_iack_fwd_lvl != 3'd0) &&
        (!rm_iack_fwd_vld || rm_iack_fwd_lvl != 3'd0));
endmodule

bind irq_line_router irq_router_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .soft_rst        (soft_rst),
    .reg_rdata       (reg_rdata),
    .loc_irq_n       (loc_irq_n),
    .bp_irq_in_n     (bp_irq_in_n),
    .bp_irq_drv_n    (bp_irq_drv_n),
    .rm_irq_in_n     (rm_irq_in_n),
    .rm_irq_drv_n    (rm_irq_drv_n),
    .rm_iack_vld     (rm_iack_vld),
    .rm_iack_lvl     (rm_iack_lvl),
    .bp_iack_vld     (bp_iack_vld),
    .bp_iack_lvl     (bp_iack_lvl),
    .bp_iack_fwd_vld (bp_iack_fwd_vld),
    .bp_iack_fwd_lvl (bp_iack_fwd_lvl),
    .rm_iack_fwd_vld (rm_iack_fwd_vld),
    .rm_iack_fwd_lvl (rm_iack_fwd_lvl)
);

// File: tb/tb_irq_line_router.sv
`timescale 1ns/1ps
module tb_irq_line_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_byte_en = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [6:0]  loc_irq_n = 7'h7F;
    logic [6:0]  bp_ext_n = 7'h7F;
    logic [6:0]  rm_ext_n = 7'h7F;
    logic [6:0]  bp_irq_in_n, bp_irq_drv_n, rm_irq_in_n, rm_irq_drv_n;
    logic        bp_iack_vld = 1'b0, rm_iack_vld = 1'b0;
    logic [2:0]  bp_iack_lvl = 3'd0, rm_iack_lvl = 3'd0;
    logic        bp_iack_fwd_vld, rm_iack_fwd_vld;
    logic [2:0]  bp_iack_fwd_lvl, rm_iack_fwd_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Wired-OR lines: external pullers and the bridge's own pull-downs.
    assign bp_irq_in_n = bp_ext_n & bp_irq_drv_n;
    assign rm_irq_in_n = rm_ext_n & rm_irq_drv_n;

    irq_line_router dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_wr_en(reg_wr_en), .reg_byte_en(reg_byte_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .loc_irq_n(loc_irq_n),
        .bp_irq_in_n(bp_irq_in_n), .bp_irq_drv_n(bp_irq_drv_n),
        .rm_irq_in_n(rm_irq_in_n), .rm_irq_drv_n(rm_irq_drv_n),
        .bp_iack_vld(bp_iack_vld), .bp_iack_lvl(bp_iack_lvl),
        .rm_iack_vld(rm_iack_vld), .rm_iack_lvl(rm_iack_lvl),
        .bp_iack_fwd_vld(bp_iack_fwd_vld), .bp_iack_fwd_lvl(bp_iack_fwd_lvl),
        .rm_iack_fwd_vld(rm_iack_fwd_vld), .rm_iack_fwd_lvl(rm_iack_fwd_lvl)
    );

    typedef struct packed {
        logic [6:0] en;
        logic [6:0] dir;
        logic [6:0] bp_req;
        logic [6:0] rm_req;
        logic [6:0] exp_bp;
        logic [6:0] exp_rm;
    } vec_t;

    // Requests and expected pulls are active-high masks, index = level-1.
    localparam vec_t VECS [0:5] = '{
        '{7'h7F, 7'h7F, 7'h55, 7'h2A, 7'h00, 7'h55},
        '{7'h7F, 7'h00, 7'h55, 7'h2A, 7'h2A, 7'h00},
        '{7'h00, 7'h7F, 7'h7F, 7'h7F, 7'h00, 7'h00},
        '{7'h0F, 7'h33, 7'h7F, 7'h7F, 7'h0C, 7'h03},
        '{7'h70, 7'h50, 7'h10, 7'h20, 7'h20, 7'h10},
        '{7'h7F, 7'h0F, 7'h70, 7'h0F, 7'h00, 7'h00}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] be, input logic [15:0] data);
        reg_wr_en   = 1'b1;
        reg_byte_en = be;
        reg_wdata   = data;
        step();
        reg_wr_en   = 1'b0;
        reg_byte_en = 2'b00;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R4 reset rdata", reg_rdata, 16'h0000);
        check("R4 reset drives", {2'b0, bp_irq_drv_n, rm_irq_drv_n}, 16'h3FFF);
        rst_n = 1'b1;
        step();
        check("R4 after release", {2'b0, bp_irq_drv_n, rm_irq_drv_n}, 16'h3FFF);

        // R1 R2 all ones, reserved bits dropped
        wr_reg(2'b11, 16'hFFFF);
        check("R2 reserved read zero", reg_rdata, 16'h7F7F);
        // R3 byte lanes
        wr_reg(2'b01, 16'h0000);
        check("R3 low byte only", reg_rdata, 16'h7F00);
        wr_reg(2'b10, 16'h12FF);
        check("R3 high byte only", reg_rdata, 16'h1200);

        // R1 level 3 mapping: enable bit 10, direction bit 2
        bp_ext_n = 7'h00;
        wr_reg(2'b11, 16'h0404);
        check("R1 readback", reg_rdata, 16'h0404);
        step();
        check("R1 level3 outward only", {9'b0, ~rm_irq_drv_n}, 16'h0004);
        bp_ext_n = 7'h7F;
        step();

        // Vector table: R6 R7 R8 R9
        for (int i = 0; i < 6; i++) begin
            wr_reg(2'b11, {1'b0, VECS[i].en, 1'b0, VECS[i].dir});
            bp_ext_n = ~VECS[i].bp_req;
            rm_ext_n = ~VECS[i].rm_req;
            step();
            check($sformatf("R6 R8 R9 vec%0d remote pulls", i), {9'b0, ~rm_irq_drv_n}, {9'b0, VECS[i].exp_rm});
            check($sformatf("R7 R8 R9 vec%0d backplane pulls", i), {9'b0, ~bp_irq_drv_n}, {9'b0, VECS[i].exp_bp});
        end
        bp_ext_n = 7'h7F;
        rm_ext_n = 7'h7F;
        step();

        // R10 release on source deassert and on disable
        wr_reg(2'b11, 16'h7F7F);
        bp_ext_n = 7'h7E;
        step();
        check("R10 forwarded", {9'b0, ~rm_irq_drv_n}, 16'h0001);
        bp_ext_n = 7'h7F;
        step();
        check("R10 released after source drop", {9'b0, ~rm_irq_drv_n}, 16'h0000);
        bp_ext_n = 7'h7E;
        step();
        wr_reg(2'b10, 16'h0000);
        check("R10 released on disable", {9'b0, ~rm_irq_drv_n}, 16'h0000);
        bp_ext_n = 7'h7F;

        // R11 local interrupt
        wr_reg(2'b11, 16'h0000);
        loc_irq_n = 7'h7E;
        #1;
        check("R11 local drives backplane", {9'b0, bp_irq_drv_n}, 16'h007E);
        step();
        check("R11 local not sent when disabled", {9'b0, rm_irq_drv_n}, 16'h007F);
        wr_reg(2'b11, 16'h0101);
        step();
        check("R11 local sent outward", {9'b0, ~rm_irq_drv_n}, 16'h0001);
        loc_irq_n = 7'h7F;
        step();
        check("R10 local drop releases remote", {9'b0, ~rm_irq_drv_n}, 16'h0000);

        // R12 R13 acknowledge steering, levels 1-4 outward, 5-7 inward
        wr_reg(2'b11, 16'h7F0F);
        bp_iack_vld = 1'b1; bp_iack_lvl = 3'd6;
        rm_iack_vld = 1'b1; rm_iack_lvl = 3'd2;
        step();
        check("R12 bp ack lvl6 to remote", {12'b0, rm_iack_fwd_vld, rm_iack_fwd_lvl}, 16'h000E);
        check("R12 rm ack lvl2 to backplane", {12'b0, bp_iack_fwd_vld, bp_iack_fwd_lvl}, 16'h000A);
        bp_iack_lvl = 3'd2;
        rm_iack_lvl = 3'd6;
        step();
        check("R13 wrong side bp ack", {15'b0, rm_iack_fwd_vld}, 16'h0000);
        check("R13 wrong side rm ack", {15'b0, bp_iack_fwd_vld}, 16'h0000);
        bp_iack_lvl = 3'd0;
        rm_iack_lvl = 3'd0;
        step();
        check("R13 level code zero", {14'b0, bp_iack_fwd_vld, rm_iack_fwd_vld}, 16'h0000);
        wr_reg(2'b10, 16'h0000);
        bp_iack_lvl = 3'd6;
        rm_iack_lvl = 3'd2;
        step();
        check("R13 disabled level ack", {14'b0, bp_iack_fwd_vld, rm_iack_fwd_vld}, 16'h0000);
        bp_iack_vld = 1'b0;
        rm_iack_vld = 1'b0;

        // R5 soft reset
        wr_reg(2'b11, 16'h7F7F);
        bp_ext_n = 7'h00;
        step();
        check("R5 before soft reset", {9'b0, ~rm_irq_drv_n}, 16'h007F);
        soft_rst = 1'b1;
        rm_iack_vld = 1'b1; rm_iack_lvl = 3'd3;
        step();
        check("R5 soft reset releases", {9'b0, ~rm_irq_drv_n}, 16'h0000);
        check("R5 soft reset ack blocked", {15'b0, bp_iack_fwd_vld}, 16'h0000);
        check("R5 soft reset keeps config", reg_rdata, 16'h7F7F);
        soft_rst = 1'b0;
        rm_iack_vld = 1'b0;
        step();
        check("R5 forwarding resumes", {9'b0, ~rm_irq_drv_n}, 16'h007F);

        // R4 hard reset mid-run
        rst_n = 1'b0;
        #1;
        check("R4 hard reset clears config", reg_rdata, 16'h0000);
        check("R4 hard reset releases remote", {9'b0, rm_irq_drv_n}, 16'h007F);
        bp_ext_n = 7'h7F;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule